// File: doc/BRIEF.md
# Output Load Diagnostic Sequencer

This block is the control side of an output-load checker for a bridged audio power stage. It steps through three load tests in a fixed order: output tied to a supply rail, the two outputs tied together, and no load present. At the last tick of each test it samples the matching comparator flag. Over-current and over-temperature are watched on every cycle. Any fault that is seen is latched. The latch shuts the amplifier off and can pull an active-low fault flag through an output enable. Both stay latched until software gives the clear bit a rising edge.

After reset the full sequence always runs, and the amplifier stays off while it does. During that time the block raises a hold signal, and configuration changes are not taken up until the sequence ends. After that, software starts a pass with a rising edge on the run-enable field. The pass is either one-shot, or repeated with a fixed idle gap between passes. Per-class mask bits keep a fault off the flag pin, but that fault still shuts the amplifier off. Time is counted in ticks of TICK_DIV clocks. A test phase lasts PHASE_TICKS ticks, and the gap between repeated passes lasts GAP_TICKS ticks.

Top module: `diag_sequencer`

## Requirements
- R1: Out of reset the block runs rail, short and open tests whatever the run-enable field holds. Each test lasts PHASE_TICKS*TICK_DIV cycles. test_sel reads 1, 2, 3 for the three tests and 0 when none runs. diag_busy is high and amp_en is low for the whole sequence.
- R2: reg_hold is high only during the power-up sequence. Configuration inputs changed then take effect one cycle after reg_hold falls.
- R3: A rising edge of cfg_diag_rst ends the power-up sequence early, aborts any pass in progress and stops repeated passes. diag_busy is low from the next cycle on.
- R4: A pass starts two cycles after cfg_diag_en rises. With cfg_diag_cont low it runs once, and holding cfg_diag_en high starts no further pass.
- R5: With cfg_diag_cont high, a new pass starts GAP_TICKS*TICK_DIV cycles after the previous one ends, and amp_en is high during the gap. Clearing cfg_diag_cont stops further passes.
- R6: A test's comparator is sampled only in the last cycle of its phase. A hit there ends the sequence, and diag_busy is low the next cycle. A pulse earlier in the phase has no effect.
- R7: cfg_mask bit positions are: 0 rail short, 1 outputs shorted, 2 open load, 3 over-current, 4 over-temperature. A fault whose mask bit is 1 leaves fault_pull low but still forces amp_en low.
- R8: Over-current and over-temperature are watched in every cycle, with or without a pass running. One cycle after a flag is seen, amp_en is low, and fault_pull is high if the fault is unmasked.
- R9: fault_pull and the amplifier shutdown stay latched after the condition goes away and through later clean passes. Both clear one cycle after a rising edge of cfg_diag_rst.
- R10: amp_en is high only when the applied power bit is 1, no fault is latched and no test runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_diag_en | input | 1 | Run-enable field; a rising edge starts a pass |
| cfg_diag_cont | input | 1 | 1 = repeated passes, 0 = one-shot |
| cfg_diag_rst | input | 1 | Clear field; a rising edge clears faults and stops testing |
| cfg_mask | input | 5 | Per-class flag mask, bit order as in R7 |
| cfg_power_on | input | 1 | Amplifier power request |
| sns_rail_short | input | 1 | Comparator: output tied to a rail |
| sns_out_short | input | 1 | Comparator: outputs tied together |
| sns_open_load | input | 1 | Comparator: no load present |
| sns_over_cur | input | 1 | Comparator: output current over limit |
| sns_over_temp | input | 1 | Comparator: die over temperature |
| amp_en | output | 1 | Amplifier output stage enable |
| diag_busy | output | 1 | A test phase is running |
| test_sel | output | 2 | Running test: 0 none, 1 rail, 2 short, 3 open |
| reg_hold | output | 1 | Configuration updates deferred |
| fault_pull | output | 1 | 1 = pull the active-low fault flag low |

## Verification
The results fall due at different cycles after a stimulus:

| Stimulus | Result | Due |
|---|---|---|
| Rising edge of cfg_diag_en | diag_busy rises | 2 cycles later (shadow register, then edge detect) |
| Rising edge of cfg_diag_rst | Faults clear, testing stops | 1 cycle later |
| Over-current or over-temperature flag | Fault latched | 1 cycle later |
| Test comparator | Sampled | Only in cycle 8k-1 of a phase in the bench set-up |
| Comparator hit | Fault latched | The cycle after the sample |
| End of power-up sequence | Held configuration applied | 1 cycle after reg_hold falls |

The driver changes inputs one nanosecond after a rising edge. It counts the edges since that change and queues the expected output values for the current cycle. The monitor pops those values and compares them at the next falling edge, so each expectation is fixed to an exact cycle.

// File: rtl/diag_pkg.sv
`timescale 1ns/1ps
package diag_pkg;
  localparam int NUM_CLS   = 5;
  localparam int NUM_TESTS = 3;
  localparam int CLS_RAIL  = 0;
  localparam int CLS_SHORT = 1;
  localparam int CLS_OPEN  = 2;
  localparam int CLS_OCP   = 3;
  localparam int CLS_OTP   = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAIL  = 3'd1,
    ST_SHORT = 3'd2,
    ST_OPEN  = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_e;

  typedef logic [1:0] test_sel_t;
  localparam test_sel_t SEL_NONE  = 2'd0;
  localparam test_sel_t SEL_RAIL  = 2'd1;
  localparam test_sel_t SEL_SHORT = 2'd2;
  localparam test_sel_t SEL_OPEN  = 2'd3;
endpackage

// File: rtl/diag_cfg_shadow.sv
`timescale 1ns/1ps
module diag_cfg_shadow
  import diag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               in_en,
  input  logic               in_cont,
  input  logic               in_clr,
  input  logic [NUM_CLS-1:0] in_mask,
  input  logic               in_pwr,
  output logic               cont_o,
  output logic               pwr_o,
  output logic [NUM_CLS-1:0] mask_o,
  output logic               en_rise_o,
  output logic               clr_rise_o
);
  logic               en_q, en_d, cont_q, cont_d, pwr_q, pwr_d;
  logic [NUM_CLS-1:0] mask_q, mask_d;
  logic               en_prev_q, clr_prev_q;

  // applied copy only follows the register fields when not held
  always_comb begin
    en_d   = en_q;
    cont_d = cont_q;
    pwr_d  = pwr_q;
    mask_d = mask_q;
    if (!hold) begin
      en_d   = in_en;
      cont_d = in_cont;
      pwr_d  = in_pwr;
      mask_d = in_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      cont_q     <= 1'b0;
      pwr_q      <= 1'b0;
      mask_q     <= '0;
      en_prev_q  <= 1'b0;
      clr_prev_q <= 1'b0;
    end else begin
      en_q       <= en_d;
      cont_q     <= cont_d;
      pwr_q      <= pwr_d;
      mask_q     <= mask_d;
      en_prev_q  <= en_q;
      clr_prev_q <= in_clr;
    end
  end

  assign cont_o     = cont_q;
  assign pwr_o      = pwr_q;
  assign mask_o     = mask_q;
  assign en_rise_o  = en_q & ~en_prev_q;
  // the clear bit acts at once, even while other fields are held
  assign clr_rise_o = in_clr & ~clr_prev_q;
endmodule

// File: rtl/diag_tick_timer.sv
`timescale 1ns/1ps
module diag_tick_timer #(
  parameter int TICK_DIV = 250,
  parameter int TW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          done
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] pre_q, pre_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          tick;

  assign tick = (pre_q == CW'(TICK_DIV - 1));
  assign done = run & tick & (cnt_q == limit - TW'(1));

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (!run || done) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = cnt_q + TW'(1);
    end else begin
      pre_d = pre_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // R1: tick count never runs past the phase length
  a_r1_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/diag_seq_fsm.sv
`timescale 1ns/1ps
module diag_seq_fsm
  import diag_pkg::*;
#(
  parameter int TW          = 16,
  parameter int PHASE_TICKS = 19333,
  parameter int GAP_TICKS   = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_rise,
  input  logic                 clr_rise,
  input  logic                 cont,
  input  logic                 prot,
  input  logic                 hit,
  input  logic                 done,
  output logic                 busy,
  output logic                 pwrup,
  output logic                 run,
  output logic [TW-1:0]        limit,
  output test_sel_t            sel,
  output logic [NUM_TESTS-1:0] strobe
);
  seq_state_e st_q, st_d;
  logic       pwrup_q, pwrup_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (en_rise) st_d = ST_RAIL;
      ST_RAIL:  if (hit) st_d = ST_IDLE; else if (done) st_d = ST_SHORT;
      ST_SHORT: if (hit) st_d = ST_IDLE; else if (done) st_d = ST_OPEN;
      ST_OPEN: begin
        if (hit) st_d = ST_IDLE;
        else if (done) st_d = (cont && !pwrup_q && !prot) ? ST_GAP : ST_IDLE;
      end
      ST_GAP: begin
        if (hit || prot || !cont) st_d = ST_IDLE;
        else if (done) st_d = ST_RAIL;
      end
      default:  st_d = ST_IDLE;
    endcase
    if (clr_rise) st_d = ST_IDLE;
    pwrup_d = pwrup_q && (st_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RAIL;
      pwrup_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      pwrup_q <= pwrup_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_RAIL:  sel = SEL_RAIL;
      ST_SHORT: sel = SEL_SHORT;
      ST_OPEN:  sel = SEL_OPEN;
      default:  sel = SEL_NONE;
    endcase
  end

  generate
    for (genvar k = 0; k < NUM_TESTS; k++) begin : g_strobe
      assign strobe[k] = done & (st_q == seq_state_e'(k + 1));
    end
  endgenerate

  assign busy  = (st_q == ST_RAIL) || (st_q == ST_SHORT) || (st_q == ST_OPEN);
  assign pwrup = pwrup_q;
  assign run   = (st_q != ST_IDLE);
  assign limit = (st_q == ST_GAP) ? TW'(GAP_TICKS) : TW'(PHASE_TICKS);

  // R1: the short test is entered only from the rail test
  a_r1_short_after_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHORT) |-> ($past(st_q) == ST_RAIL || $past(st_q) == ST_SHORT));
  // R2: the power-up hold only exists while a test runs
  a_r2_hold_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup_q |-> busy);
  // R3: a clear edge stops any testing
  a_r3_clear_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rise |=> (st_q == ST_IDLE));
  // R4: an enable edge in idle starts a pass
  a_r4_edge_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && en_rise && !clr_rise) |=> busy);
endmodule

// File: rtl/diag_fault_latch.sv
`timescale 1ns/1ps
module diag_fault_latch
  import diag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLS-1:0] strobe,
  input  logic [NUM_CLS-1:0] sense,
  input  logic [NUM_CLS-1:0] mask,
  input  logic               clr,
  output logic               hit,
  output logic               prot,
  output logic               pull
);
  logic [NUM_CLS-1:0] evt, flag_evt;
  logic               prot_q, prot_d, pull_q, pull_d;

  generate
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      assign evt[c]      = strobe[c] & sense[c];
      assign flag_evt[c] = evt[c] & ~mask[c];
    end
  endgenerate

  assign hit = |evt;

  always_comb begin
    prot_d = prot_q | hit;
    pull_d = pull_q | (|flag_evt);
    if (clr) begin
      prot_d = 1'b0;
      pull_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      prot_q <= prot_d;
      pull_q <= pull_d;
    end
  end

  assign prot = prot_q;
  assign pull = pull_q;

  // R9: flag stays asserted until a clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q && !clr) |=> pull_q);
  // R7: the flag never shows without the output shutdown
  a_r7_flag_with_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> prot_q);
endmodule

// File: rtl/diag_sequencer.sv
`timescale 1ns/1ps
module diag_sequencer
  import diag_pkg::*;
#(
  parameter int TICK_DIV    = 250,
  parameter int PHASE_TICKS = 19333,
  parameter int GAP_TICKS   = 2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_diag_en,
  input  logic               cfg_diag_cont,
  input  logic               cfg_diag_rst,
  input  logic [NUM_CLS-1:0] cfg_mask,
  input  logic               cfg_power_on,
  input  logic               sns_rail_short,
  input  logic               sns_out_short,
  input  logic               sns_open_load,
  input  logic               sns_over_cur,
  input  logic               sns_over_temp,
  output logic               amp_en,
  output logic               diag_busy,
  output logic [1:0]         test_sel,
  output logic               reg_hold,
  output logic               fault_pull
);
  localparam int MAX_TICKS = (PHASE_TICKS > GAP_TICKS) ? PHASE_TICKS : GAP_TICKS;
  localparam int TW        = $clog2(MAX_TICKS + 1);

  logic                 cont_a, pwr_a, en_rise, clr_rise;
  logic [NUM_CLS-1:0]   mask_a, strobe_all, sense_all;
  logic                 busy, pwrup, run, done, hit, prot, pull;
  logic [TW-1:0]        limit;
  logic [NUM_TESTS-1:0] strobe_t;
  test_sel_t            sel;

  diag_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .hold(pwrup),
    .in_en(cfg_diag_en), .in_cont(cfg_diag_cont), .in_clr(cfg_diag_rst),
    .in_mask(cfg_mask), .in_pwr(cfg_power_on),
    .cont_o(cont_a), .pwr_o(pwr_a), .mask_o(mask_a),
    .en_rise_o(en_rise), .clr_rise_o(clr_rise)
  );

  diag_tick_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .limit(limit), .done(done)
  );

  diag_seq_fsm #(.TW(TW), .PHASE_TICKS(PHASE_TICKS), .GAP_TICKS(GAP_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_rise(en_rise), .clr_rise(clr_rise),
    .cont(cont_a), .prot(prot), .hit(hit), .done(done),
    .busy(busy), .pwrup(pwrup), .run(run), .limit(limit),
    .sel(sel), .strobe(strobe_t)
  );

  // load tests sample once per phase; protection classes every cycle
  assign strobe_all[CLS_RAIL]  = strobe_t[0];
  assign strobe_all[CLS_SHORT] = strobe_t[1];
  assign strobe_all[CLS_OPEN]  = strobe_t[2];
  assign strobe_all[CLS_OCP]   = 1'b1;
  assign strobe_all[CLS_OTP]   = 1'b1;

  assign sense_all[CLS_RAIL]  = sns_rail_short;
  assign sense_all[CLS_SHORT] = sns_out_short;
  assign sense_all[CLS_OPEN]  = sns_open_load;
  assign sense_all[CLS_OCP]   = sns_over_cur;
  assign sense_all[CLS_OTP]   = sns_over_temp;

  diag_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .strobe(strobe_all), .sense(sense_all),
    .mask(mask_a), .clr(clr_rise), .hit(hit), .prot(prot), .pull(pull)
  );

  assign amp_en     = pwr_a & ~prot & ~busy;
  assign diag_busy  = busy;
  assign test_sel   = sel;
  assign reg_hold   = pwrup;
  assign fault_pull = pull;

  // R8: an over-current flag shuts the output the next cycle
  a_r8_overcur_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    (sns_over_cur && !clr_rise) |=> !amp_en);
endmodule

// File: tb/diag_sequencer_tb.sv
`timescale 1ns/1ps
module diag_sequencer_tb;
  localparam int PH  = 8;       // TICK_DIV 2 x PHASE_TICKS 4
  localparam int RUN = 3 * PH;
  localparam int GAP = 12;      // TICK_DIV 2 x GAP_TICKS 6

  logic       clk = 1'b0;
  logic       rst_n;
  logic       diag_en, diag_cont, diag_rst, power_on;
  logic [4:0] mask;
  logic       s_rail, s_short, s_open, s_ocp, s_otp;
  logic       amp_en, diag_busy, reg_hold, fault_pull;
  logic [1:0] test_sel;

  typedef struct {
    string      req;
    logic       amp;
    logic       pull;
    logic       busy;
    logic       hold;
    logic [1:0] sel;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  diag_sequencer #(.TICK_DIV(2), .PHASE_TICKS(4), .GAP_TICKS(6)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_diag_en(diag_en), .cfg_diag_cont(diag_cont), .cfg_diag_rst(diag_rst),
    .cfg_mask(mask), .cfg_power_on(power_on),
    .sns_rail_short(s_rail), .sns_out_short(s_short), .sns_open_load(s_open),
    .sns_over_cur(s_ocp), .sns_over_temp(s_otp),
    .amp_en(amp_en), .diag_busy(diag_busy), .test_sel(test_sel),
    .reg_hold(reg_hold), .fault_pull(fault_pull)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic expect_out(string req, logic amp, logic pull, logic busy,
                            logic hold, logic [1:0] sel);
    exp_t e;
    e.req = req; e.amp = amp; e.pull = pull; e.busy = busy; e.hold = hold; e.sel = sel;
    sbq.push_back(e);
  endtask

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    exp_t e;
    while (sbq.size() > 0) begin
      e = sbq.pop_front();
      check(e.req, "amp_en",     8'(amp_en),     8'(e.amp));
      check(e.req, "fault_pull", 8'(fault_pull), 8'(e.pull));
      check(e.req, "diag_busy",  8'(diag_busy),  8'(e.busy));
      check(e.req, "reg_hold",   8'(reg_hold),   8'(e.hold));
      check(e.req, "test_sel",   8'(test_sel),   8'(e.sel));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] run_sel(int i, int s);
    if (i < s || i >= s + RUN) return 2'd0;
    return 2'((i - s) / PH + 1);
  endfunction

  function automatic logic in_run(int i, int s);
    return (i >= s) && (i < s + RUN);
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic rearm_en();
    diag_en = 1'b0;
    step();
    step();
    diag_en = 1'b1;
  endtask

  task automatic pulse_clear();
    diag_rst = 1'b1;
    step();
    diag_rst = 1'b0;
    step();
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    rst_n = 1'b0;
    diag_en = 0; diag_cont = 0; diag_rst = 0; power_on = 0; mask = 5'b0;
    s_rail = 0; s_short = 0; s_open = 0; s_ocp = 0; s_otp = 0;
    repeat (3) step();
    expect_out("R1 reset", 1'b0, 1'b0, 1'b1, 1'b1, 2'd1);
    step();

    // power-up sequence; power request written while held (R1, R2)
    rst_n = 1'b1;
    for (int i = 0; i <= 26; i++) begin
      if (i == 3) power_on = 1'b1;
      expect_out(i < 24 ? "R1 powerup" : "R2 held write",
                 i >= 25, 1'b0, i < 24, i < 24, i < 24 ? 2'(i / PH + 1) : 2'd0);
      step();
    end

    // one-shot pass, enable kept high afterwards (R4)
    diag_en = 1'b1;
    for (int i = 0; i <= 44; i++) begin
      expect_out("R4 oneshot", !in_run(i, 2), 1'b0, in_run(i, 2), 1'b0, run_sel(i, 2));
      step();
    end

    // repeated passes, then stop by clearing the mode bit (R5)
    diag_cont = 1'b1;
    rearm_en();
    for (int i = 0; i <= 95; i++) begin
      logic b;
      if (i == 63) diag_cont = 1'b0;
      b = in_run(i, 2) || in_run(i, 2 + RUN + GAP);
      expect_out("R5 continuous", !b, 1'b0, b, 1'b0, run_sel(i, 2) | run_sel(i, 2 + RUN + GAP));
      step();
    end

    // repeated passes stopped by the clear edge (R3)
    diag_cont = 1'b1;
    rearm_en();
    for (int i = 0; i <= 50; i++) begin
      logic b;
      if (i == 10) diag_rst = 1'b1;
      b = in_run(i, 2) && (i <= 10);
      expect_out("R3 clear aborts", !b, 1'b0, b, 1'b0, b ? run_sel(i, 2) : 2'd0);
      step();
    end
    diag_rst = 1'b0;
    diag_cont = 1'b0;
    step();

    // comparator pulse away from the sampling cycle is ignored (R6)
    rearm_en();
    for (int i = 0; i <= 30; i++) begin
      if (i == 11) s_short = 1'b1;
      if (i == 13) s_short = 1'b0;
      expect_out("R6 pulse ignored", !in_run(i, 2), 1'b0, in_run(i, 2), 1'b0, run_sel(i, 2));
      step();
    end

    // outputs shorted together, sampled at end of short phase (R6)
    s_short = 1'b1;
    rearm_en();
    for (int i = 0; i <= 25; i++) begin
      logic b;
      b = in_run(i, 2) && (i < 18);
      expect_out("R6 short hit", i < 2, i >= 18, b, 1'b0, b ? run_sel(i, 2) : 2'd0);
      step();
    end
    s_short = 1'b0;
    // sticky after the condition goes and through a clean pass (R9)
    for (int i = 0; i < 10; i++) begin
      expect_out("R9 sticky idle", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
      step();
    end
    rearm_en();
    for (int i = 0; i <= 30; i++) begin
      expect_out("R9 sticky rerun", 1'b0, 1'b1, in_run(i, 2), 1'b0, run_sel(i, 2));
      step();
    end
    diag_rst = 1'b1;
    expect_out("R9 before clear", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    step();
    expect_out("R9 cleared", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    diag_rst = 1'b0;
    step();

    // masked rail short: no flag, output still shut (R7)
    mask = 5'b00001;
    s_rail = 1'b1;
    rearm_en();
    for (int i = 0; i <= 14; i++) begin
      logic b;
      b = in_run(i, 2) && (i < 10);
      expect_out("R7 masked rail", i < 2, 1'b0, b, 1'b0, b ? run_sel(i, 2) : 2'd0);
      step();
    end
    s_rail = 1'b0;
    mask = 5'b0;
    pulse_clear();
    expect_out("R9 clear masked", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    step();

    // over-current while idle (R8), sticky (R9)
    s_ocp = 1'b1;
    expect_out("R8 ocp same cycle", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    step();
    expect_out("R8 ocp latched", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    s_ocp = 1'b0;
    repeat (4) step();
    expect_out("R9 ocp sticky", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    step();
    pulse_clear();

    // masked over-current (R7)
    mask = 5'b01000;
    step();
    step();
    s_ocp = 1'b1;
    step();
    expect_out("R7 masked ocp", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    s_ocp = 1'b0;
    step();
    pulse_clear();
    mask = 5'b0;
    step();
    step();

    // unmasked over-temperature (R8)
    s_otp = 1'b1;
    step();
    expect_out("R8 otp latched", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    s_otp = 1'b0;
    step();
    pulse_clear();
    expect_out("R9 otp cleared", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    step();

    // power request gates the output (R10)
    power_on = 1'b0;
    expect_out("R10 power still on", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    step();
    expect_out("R10 power off", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    power_on = 1'b1;
    step();
    step();
    expect_out("R10 power back", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    step();

    // clear edge ends the power-up sequence early (R3)
    rst_n = 1'b0;
    diag_en = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    for (int i = 0; i <= 7; i++) begin
      if (i == 3) diag_rst = 1'b1;
      expect_out("R3 powerup abort", i >= 5, 1'b0, i < 4, i < 4, i < 4 ? 2'd1 : 2'd0);
      step();
    end
    diag_rst = 1'b0;
    step();
    @(negedge clk);
    #1;
    report();
  end
endmodule